// File: doc/BRIEF.md
# Vector Element Scalar Transfer Unit

This block moves 16-bit values between the scalar side of a processor and a bank of wide vector registers. It also moves them to and from a small set of 16-bit vector control registers. Each vector register holds 128 bits and is addressed as 16 bytes. Byte 0 is the most significant byte, so byte i occupies bits 127-8i down to 120-8i. An element is addressed by a byte index. The access always covers that byte and the next one, and the pair wraps from byte 15 back to byte 0.

Each operation is launched by a one-cycle start strobe together with a 32-bit instruction word and a 32-bit scalar source value. One clock later the block presents the following as registered outputs:
- the scalar writeback with its enable and target index,
- a copy of any vector register it rewrote,
- any control register it rewrote,
- a done pulse, and an illegal flag for unsupported operation codes.

The vector bank and the control registers are held inside the block.

Top module: `vec_xfer_unit`

## Requirements
- R1: Instruction bits 25:21 select the operation: 0x00 vector-to-scalar, 0x02 control-to-scalar, 0x04 scalar-to-vector, 0x06 scalar-to-control. Any other value raises illegal_o for one cycle and writes no state and no scalar register.
- R2: The scalar register index is instruction bits 20:16, the vector or control register index is bits 15:11, and the starting byte index e is bits 10:7.
- R3: Vector-to-scalar returns byte e as bits 15:8 and byte e+1 as bits 7:0, sign-extended to 32 bits. Byte i is bits 127-8i:120-8i of the register.
- R4: The second byte is (e+1) mod 16, so e=15 pairs byte 15 with byte 0, for both reads and writes.
- R5: Scalar-to-vector writes scalar bits 15:8 to byte e and bits 7:0 to byte e+1, leaving every other byte and register unchanged. vec_data_o shows the whole updated register.
- R6: Scalar-to-control stores only scalar bits 15:0. Control-to-scalar returns the 16-bit value zero-extended.
- R7: There are four control registers. Indices 4 to 31 read as zero, and writes to them change nothing and do not assert ctrl_we_o.
- R8: A scalar writeback targeting register 0 is suppressed: wb_en_o stays low.
- R9: All outputs are registered and valid exactly one cycle after start_i, with done_o pulsing then. Every output that is not asserted, and every data or index output whose enable is low, reads zero. With start_i low, no state changes.
- R10: After reset all vector and control registers are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one operation this cycle |
| instr_i | input | 32 | Instruction word |
| scalar_i | input | 32 | Scalar source value |
| done_o | output | 1 | Operation completed (one cycle after start) |
| illegal_o | output | 1 | Unsupported operation code |
| wb_en_o | output | 1 | Scalar writeback enable |
| wb_idx_o | output | 5 | Scalar writeback register index |
| wb_data_o | output | 32 | Scalar writeback value |
| vec_we_o | output | 1 | A vector register was rewritten |
| vec_idx_o | output | 5 | Index of rewritten vector register |
| vec_data_o | output | 128 | New contents of that vector register |
| ctrl_we_o | output | 1 | A control register was rewritten |
| ctrl_idx_o | output | 5 | Index of rewritten control register |
| ctrl_data_o | output | 16 | New control register value |

## Verification
The assertions assume start_i and instr_i are clean after reset. They also assume that every strobe is followed by a full result cycle before the next operation depends on its state. The stimulus respects this by driving on the falling edge, holding start_i for exactly one cycle and leaving an idle cycle between operations. A behavioural model keeps its own byte arrays and is updated only after each comparison. Directed cases cover byte 15 wrap, register 0 suppression, out-of-range control indices and illegal codes. Randomized operations then mix all four moves with unsupported codes.

// File: rtl/vxu_pkg.sv
package vxu_pkg;
  typedef enum logic [4:0] {
    OP_V2S = 5'h00,
    OP_C2S = 5'h02,
    OP_S2V = 5'h04,
    OP_S2C = 5'h06
  } vxu_op_e;

  typedef struct packed {
    logic      legal;
    vxu_op_e   op;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [3:0] el;
  } vxu_dec_t;
endpackage

// File: rtl/vxu_decode.sv
module vxu_decode
  import vxu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr_i,
  output vxu_dec_t        dec_o
);
  logic unused_bits;
  assign unused_bits = ^{instr_i[XLEN-1:26], instr_i[6:0]};

  always_comb begin
    dec_o.rt    = instr_i[20:16];
    dec_o.rd    = instr_i[15:11];
    dec_o.el    = instr_i[10:7];
    dec_o.legal = 1'b1;
    dec_o.op    = OP_V2S;
    case (instr_i[25:21])
      5'h00:   dec_o.op = OP_V2S;
      5'h02:   dec_o.op = OP_C2S;
      5'h04:   dec_o.op = OP_S2V;
      5'h06:   dec_o.op = OP_S2C;
      default: dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/vxu_vec_file.sv
module vxu_vec_file #(
  parameter int NREGS  = 32,
  parameter int NBYTES = 16,
  localparam int VW    = NBYTES * 8,
  localparam int IW    = $clog2(NREGS),
  localparam int EW    = $clog2(NBYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic [EW-1:0] el_i,
  input  logic          we_i,
  input  logic [15:0]   wr_pair_i,
  output logic [15:0]   rd_pair_o,
  output logic [VW-1:0] new_row_o
);
  logic [NREGS-1:0][VW-1:0] mem;
  logic [VW-1:0]            row;
  logic [7:0]               cur_b [NBYTES];
  logic [NBYTES-1:0]        be;
  logic [EW-1:0]            el_nxt;

  assign row    = mem[idx_i];
  assign el_nxt = el_i + EW'(1);  // wraps modulo NBYTES

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign cur_b[b] = row[VW-1-8*b -: 8];
    assign be[b]    = (EW'(b) == el_i) || (EW'(b) == el_nxt);
    assign new_row_o[VW-1-8*b -: 8] =
      (EW'(b) == el_i)   ? wr_pair_i[15:8] :
      (EW'(b) == el_nxt) ? wr_pair_i[7:0]  : cur_b[b];
  end

  assign rd_pair_o = {cur_b[el_i], cur_b[el_nxt]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem <= '0;
    else if (we_i) mem[idx_i] <= new_row_o;
  end

  // R5
  two_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> $countones(be) == 2);
endmodule

// File: rtl/vxu_ctrl_file.sv
module vxu_ctrl_file #(
  parameter int NCTRL = 4,
  parameter int CW    = 16,
  parameter int IDXW  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] idx_i,
  input  logic            we_i,
  input  logic [CW-1:0]   wd_i,
  output logic [CW-1:0]   rd_o,
  output logic            hit_o
);
  logic [CW-1:0] regs [NCTRL];

  assign hit_o = idx_i < IDXW'(NCTRL);

  for (genvar i = 0; i < NCTRL; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs[i] <= '0;
      else if (we_i && idx_i == IDXW'(i))      regs[i] <= wd_i;
    end
  end

  always_comb begin
    rd_o = '0;
    for (int i = 0; i < NCTRL; i++)
      if (idx_i == IDXW'(i)) rd_o = regs[i];
  end

  // R7
  ctrl_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rd_o == '0);
endmodule

// File: rtl/vec_xfer_unit.sv
module vec_xfer_unit
  import vxu_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int NUM_VREGS = 32,
  parameter int VBYTES    = 16,
  parameter int NUM_CTRL  = 4,
  parameter int CTRL_W    = 16,
  localparam int VW       = VBYTES * 8,
  localparam int VIW      = $clog2(NUM_VREGS),
  localparam int EW       = $clog2(VBYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] scalar_i,
  output logic            done_o,
  output logic            illegal_o,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            vec_we_o,
  output logic [VIW-1:0]  vec_idx_o,
  output logic [VW-1:0]   vec_data_o,
  output logic            ctrl_we_o,
  output logic [4:0]      ctrl_idx_o,
  output logic [CTRL_W-1:0] ctrl_data_o
);
  vxu_dec_t          dec;
  logic [15:0]       pair_rd;
  logic [VW-1:0]     new_row;
  logic [CTRL_W-1:0] ctrl_rd;
  logic              ctrl_hit;
  logic              do_s2v, do_s2c, wb_ok;
  logic              unused_scalar;

  assign unused_scalar = ^scalar_i[XLEN-1:16];

  vxu_decode #(.XLEN(XLEN)) u_dec (.instr_i(instr_i), .dec_o(dec));

  assign do_s2v = start_i && dec.legal && dec.op == OP_S2V;
  assign do_s2c = start_i && dec.legal && dec.op == OP_S2C && ctrl_hit;
  assign wb_ok  = dec.rt != 5'd0;

  vxu_vec_file #(.NREGS(NUM_VREGS), .NBYTES(VBYTES)) u_vec (
    .clk_i, .rst_ni,
    .idx_i     (dec.rd[VIW-1:0]),
    .el_i      (dec.el[EW-1:0]),
    .we_i      (do_s2v),
    .wr_pair_i (scalar_i[15:0]),
    .rd_pair_o (pair_rd),
    .new_row_o (new_row)
  );

  vxu_ctrl_file #(.NCTRL(NUM_CTRL), .CW(CTRL_W), .IDXW(5)) u_ctl (
    .clk_i, .rst_ni,
    .idx_i (dec.rd),
    .we_i  (do_s2c),
    .wd_i  (scalar_i[CTRL_W-1:0]),
    .rd_o  (ctrl_rd),
    .hit_o (ctrl_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0; illegal_o <= 1'b0;
      wb_en_o <= 1'b0; wb_idx_o <= '0; wb_data_o <= '0;
      vec_we_o <= 1'b0; vec_idx_o <= '0; vec_data_o <= '0;
      ctrl_we_o <= 1'b0; ctrl_idx_o <= '0; ctrl_data_o <= '0;
    end else begin
      done_o <= start_i; illegal_o <= start_i && !dec.legal;
      wb_en_o <= 1'b0; wb_idx_o <= '0; wb_data_o <= '0;
      vec_we_o <= 1'b0; vec_idx_o <= '0; vec_data_o <= '0;
      ctrl_we_o <= 1'b0; ctrl_idx_o <= '0; ctrl_data_o <= '0;
      if (start_i && dec.legal) begin
        case (dec.op)
          OP_V2S: if (wb_ok) begin
            wb_en_o   <= 1'b1;
            wb_idx_o  <= dec.rt;
            wb_data_o <= {{(XLEN-16){pair_rd[15]}}, pair_rd};
          end
          OP_C2S: if (wb_ok) begin
            wb_en_o   <= 1'b1;
            wb_idx_o  <= dec.rt;
            wb_data_o <= XLEN'(ctrl_rd);
          end
          OP_S2V: begin
            vec_we_o   <= 1'b1;
            vec_idx_o  <= dec.rd[VIW-1:0];
            vec_data_o <= new_row;
          end
          OP_S2C: if (ctrl_hit) begin
            ctrl_we_o   <= 1'b1;
            ctrl_idx_o  <= dec.rd;
            ctrl_data_o <= scalar_i[CTRL_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  wb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_idx_o != 5'd0);
  // R9
  done_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o && !wb_en_o && !vec_we_o && !ctrl_we_o && !illegal_o);
  // R1
  illegal_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o && !vec_we_o && !ctrl_we_o);
  // R1
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({wb_en_o, vec_we_o, ctrl_we_o, illegal_o}) <= 1);
  // R7
  ctrl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_o |-> ctrl_idx_o < 5'(NUM_CTRL));
  // R6
  c2s_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && instr_i[25:21] == 5'h02 |=> wb_data_o[XLEN-1:16] == '0);
  // R3
  v2s_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && instr_i[25:21] == 5'h00 |=> wb_data_o[XLEN-1:16] == {(XLEN-16){wb_data_o[15]}});
endmodule

// File: tb/vec_xfer_unit_tb.sv
module vec_xfer_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] instr = '0, scalar = '0;
  logic done, illegal, wb_en, vec_we, ctrl_we;
  logic [4:0] wb_idx, vec_idx, ctrl_idx;
  logic [31:0] wb_data;
  logic [127:0] vec_data;
  logic [15:0] ctrl_data;

  int n_tests = 0, n_fail = 0;
  logic [127:0] mv [32];
  logic [15:0]  mc [4];

  always #2 clk = ~clk;

  vec_xfer_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr), .scalar_i(scalar),
    .done_o(done), .illegal_o(illegal), .wb_en_o(wb_en), .wb_idx_o(wb_idx),
    .wb_data_o(wb_data), .vec_we_o(vec_we), .vec_idx_o(vec_idx), .vec_data_o(vec_data),
    .ctrl_we_o(ctrl_we), .ctrl_idx_o(ctrl_idx), .ctrl_data_o(ctrl_data)
  );

  task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] get_b(input logic [127:0] v, input int i);
    logic [127:0] s;
    s = v >> (8 * (15 - i));
    return s[7:0];
  endfunction

  function automatic logic [127:0] put_b(input logic [127:0] v, input int i, input logic [7:0] b);
    logic [127:0] m;
    m = 128'hff << (8 * (15 - i));
    return (v & ~m) | ({120'd0, b} << (8 * (15 - i)));
  endfunction

  task automatic check_all(input string req, input logic e_done, e_ill, e_wb, input logic [4:0] e_wbi,
                           input logic [31:0] e_wbd, input logic e_vw, input logic [4:0] e_vi,
                           input logic [127:0] e_vd, input logic e_cw, input logic [4:0] e_ci,
                           input logic [15:0] e_cd);
    check(req, "done", 128'(done), 128'(e_done));
    check(req, "illegal", 128'(illegal), 128'(e_ill));
    check(req, "wb_en", 128'(wb_en), 128'(e_wb));
    check(req, "wb_idx", 128'(wb_idx), 128'(e_wbi));
    check(req, "wb_data", 128'(wb_data), 128'(e_wbd));
    check(req, "vec_we", 128'(vec_we), 128'(e_vw));
    check(req, "vec_idx", 128'(vec_idx), 128'(e_vi));
    check(req, "vec_data", vec_data, e_vd);
    check(req, "ctrl_we", 128'(ctrl_we), 128'(e_cw));
    check(req, "ctrl_idx", 128'(ctrl_idx), 128'(e_ci));
    check(req, "ctrl_data", 128'(ctrl_data), 128'(e_cd));
  endtask

  // Issue one op; compare one cycle later; then update the model.
  task automatic do_op(input string req, input logic [4:0] op, rt, rd, input logic [3:0] el,
                       input logic [31:0] sv);
    logic e_ill, e_wb, e_vw, e_cw;
    logic [4:0] e_wbi, e_vi, e_ci;
    logic [31:0] e_wbd;
    logic [127:0] e_vd;
    logic [15:0] e_cd;
    logic [7:0] hi, lo;
    int e1, e2;
    e1 = int'(el); e2 = (e1 + 1) % 16;
    e_ill = 0; e_wb = 0; e_vw = 0; e_cw = 0;
    e_wbi = 0; e_vi = 0; e_ci = 0; e_wbd = 0; e_vd = 0; e_cd = 0;
    case (op)
      5'h00: begin
        hi = get_b(mv[rd], e1); lo = get_b(mv[rd], e2);
        if (rt != 0) begin
          e_wb = 1; e_wbi = rt;
          e_wbd = {hi[7] ? 16'hffff : 16'h0000, hi, lo};
        end
      end
      5'h02: if (rt != 0) begin
        e_wb = 1; e_wbi = rt;
        e_wbd = (rd < 4) ? {16'h0, mc[rd[1:0]]} : 32'h0;
      end
      5'h04: begin
        e_vw = 1; e_vi = rd;
        e_vd = put_b(put_b(mv[rd], e1, sv[15:8]), e2, sv[7:0]);
      end
      5'h06: if (rd < 4) begin
        e_cw = 1; e_ci = rd; e_cd = sv[15:0];
      end
      default: e_ill = 1;
    endcase
    @(negedge clk);
    start = 1; instr = {6'h12, op, rt, rd, el, 7'h0}; scalar = sv;
    @(negedge clk);
    check_all(req, 1'b1, e_ill, e_wb, e_wbi, e_wbd, e_vw, e_vi, e_vd, e_cw, e_ci, e_cd);
    start = 0; instr = $urandom; scalar = $urandom;
    if (e_vw) mv[rd] = e_vd;
    if (e_cw) mc[rd[1:0]] = e_cd;
  endtask

  task automatic check_idle(input string req);
    @(negedge clk);
    check_all(req, 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd0, 128'd0, 1'b0, 5'd0, 16'd0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mv[i] = '0;
    for (int i = 0; i < 4; i++) mc[i] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check_all("R10", 1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 5'd0, 128'd0, 1'b0, 5'd0, 16'd0);
    rst_n = 1;
    do_op("R10", 5'h00, 5'd1, 5'd5, 4'd0, 32'h0);
    do_op("R10", 5'h02, 5'd1, 5'd3, 4'd0, 32'h0);
    // R2 R5 write element 0 of v3
    do_op("R5", 5'h04, 5'd0, 5'd3, 4'd0, 32'h1234abcd);
    // R3 negative value sign extension
    do_op("R3", 5'h00, 5'd7, 5'd3, 4'd0, 32'h0);
    do_op("R5", 5'h04, 5'd0, 5'd3, 4'd5, 32'hffff7f01);
    do_op("R3", 5'h00, 5'd8, 5'd3, 4'd5, 32'h0);
    // R3 odd start byte straddles pairs
    do_op("R3", 5'h00, 5'd9, 5'd3, 4'd1, 32'h0);
    // R4 wrap past byte 15
    do_op("R4", 5'h04, 5'd0, 5'd9, 4'd15, 32'h00005aa5);
    do_op("R4", 5'h00, 5'd2, 5'd9, 4'd15, 32'h0);
    do_op("R4", 5'h00, 5'd2, 5'd9, 4'd0, 32'h0);
    // R8 writes to register 0 are suppressed
    do_op("R8", 5'h00, 5'd0, 5'd3, 4'd0, 32'h0);
    do_op("R8", 5'h02, 5'd0, 5'd1, 4'd0, 32'h0);
    // R6 low half stored, zero-extended read
    do_op("R6", 5'h06, 5'd4, 5'd2, 4'd0, 32'hdead8001);
    do_op("R6", 5'h02, 5'd4, 5'd2, 4'd0, 32'h0);
    // R7 out-of-range control index
    do_op("R7", 5'h06, 5'd4, 5'd7, 4'd0, 32'h0000ffff);
    do_op("R7", 5'h02, 5'd4, 5'd7, 4'd0, 32'h0);
    do_op("R7", 5'h02, 5'd4, 5'd3, 4'd0, 32'h0);
    // R1 unsupported codes
    do_op("R1", 5'h01, 5'd4, 5'd3, 4'd0, 32'hffffffff);
    do_op("R1", 5'h10, 5'd4, 5'd2, 4'd0, 32'hffffffff);
    do_op("R1", 5'h00, 5'd4, 5'd3, 4'd0, 32'h0);
    do_op("R1", 5'h02, 5'd4, 5'd2, 4'd0, 32'h0);
    // R9 idle cycles leave outputs and state untouched
    for (int i = 0; i < 6; i++) begin
      instr = {6'h12, 5'h04, 5'd1, 5'd3, 4'd0, 7'h0}; scalar = $urandom;
      check_idle("R9");
    end
    do_op("R9", 5'h00, 5'd6, 5'd3, 4'd0, 32'h0);
    // R2 random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      int k;
      k = $urandom_range(0, 9);
      op = (k < 2) ? 5'h00 : (k < 4) ? 5'h04 : (k < 6) ? 5'h02 : (k < 8) ? 5'h06 : 5'($urandom);
      do_op("R2", op, 5'($urandom), 5'($urandom_range(0, 7)), 4'($urandom), $urandom);
    end
    check_idle("R9");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule